// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block issues one short, self-contained serial flash command at a time: status and ID reads, write enable, erase, or register writes carrying a few data bytes. Software describes the whole command in a single packed 32-bit command word. A write of that word with the go bit set starts the command, and a busy bit in the readback word shows when the command has finished.

A command always begins with an 8-bit opcode. An address of 1 to 4 bytes may follow, taken from a separate 32-bit address input. Then come 0 to 31 dummy clocks, then up to 8 transmit bytes taken from two 32-bit words, then up to 8 receive bytes returned in two 32-bit words. The serial side uses one lane and one bit per system clock. `spi_sclk_en` marks each active bit cycle and lets the clock pass. `spi_cs_n` frames the whole command. The address and transmit data are captured on the clock edge that starts the command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk_en` is 0, the busy bit `cmd_rdata[1]` is 0, and both receive words read 0.
- R2: A write of the command word with bit 0 set while idle sets busy on the next cycle. Busy then stays set for exactly 8 + A + D + W + R cycles, where A, D, W and R are the bit counts of the address, dummy, transmit and receive phases.
- R3: The opcode in command bits 31:24 is driven on `spi_mosi` during the first 8 active cycles, most significant bit first.
- R4: When bit 19 is set, bits 17:16 give the address byte count minus one. The low 8×N bits of `addr_in`, as captured at start, are sent most significant bit first.
- R5: Bits 11:7 give the number of dummy cycles. During these cycles `spi_sclk_en` is 1 and `spi_mosi` is 0.
- R6: When bit 15 is set, bits 14:12 give the transmit byte count minus one. Byte k is taken from bits 8k+7:8k of {`wdata_hi`,`wdata_lo`} as captured at start, and each byte is sent most significant bit first.
- R7: When bit 23 is set, bits 22:20 give the receive byte count minus one. `spi_miso` is sampled at the clock edge that ends each receive cycle. Receive bit r goes to bit 8·(r/8)+7−(r mod 8) of {`rdata_hi`,`rdata_lo`}. Bytes that are not received read 0, because a read command clears both words when it starts.
- R8: The phases run in the order opcode, address, dummy, transmit, receive. A disabled or zero-length phase takes no cycles.
- R9: `spi_cs_n` is 0 and `spi_sclk_en` is 1 exactly while busy. Both return to idle in the cycle after the last bit.
- R10: Writes to the command word while busy are ignored. The running command keeps its length and bits, and the readback word is unchanged.
- R11: A write of the command word with bit 0 clear while idle stores the word but starts nothing.
- R12: The receive words hold their value between commands and through commands that do not have bit 23 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word written on `cmd_wr` |
| cmd_rdata | output | 32 | Stored command word, bit 1 = busy, bit 0 reads 0 |
| addr_in | input | 32 | Address source, captured at start |
| wdata_lo | input | 32 | Transmit bytes 1 to 4 |
| wdata_hi | input | 32 | Transmit bytes 5 to 8 |
| rdata_lo | output | 32 | Receive bytes 1 to 4 |
| rdata_hi | output | 32 | Receive bytes 5 to 8 |
| spi_sclk_en | output | 1 | Serial clock enable, high in each bit cycle |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong phase counter or a wrong next-phase choice shows up on `spi_mosi` in the very cycle it goes wrong. It also stretches or cuts the busy window, so the length check catches it by the end of that same command. A bad receive index or a missing clear only becomes visible after busy falls, when the two receive words are read back. A command word that is overwritten while busy shows in the readback word, and also as a restarted opcode in the bit stream.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int OPC_BITS  = 8;
  localparam int BYTE_BITS = 8;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * BYTE_BITS;
  localparam int ADDR_W    = 32;
  localparam int CNT_W     = $clog2(DATA_W) + 1;
  localparam int IDX_W     = $clog2(DATA_W);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WDATA = 3'd4,
    PH_RDATA = 3'd5
  } phase_e;

  // Field positions are decoded by software; keep them fixed.
  typedef struct packed {
    logic [7:0] opcode;   // 31:24
    logic       rd_en;    // 23
    logic [2:0] rd_nm1;   // 22:20
    logic       adr_en;   // 19
    logic       rsv_a;    // 18
    logic [1:0] adr_nm1;  // 17:16
    logic       wr_en;    // 15
    logic [2:0] wr_nm1;   // 14:12
    logic [4:0] dummy;    // 11:7
    logic [4:0] rsv_b;    // 6:2
    logic       busy_ro;  // 1
    logic       go;       // 0
  } cmd_t;

  function automatic logic [CNT_W-1:0] phase_bits(phase_e p, cmd_t c);
    case (p)
      PH_OPC:   return CNT_W'(OPC_BITS);
      PH_ADDR:  return c.adr_en ? CNT_W'((int'(c.adr_nm1) + 1) * BYTE_BITS) : '0;
      PH_DUMMY: return CNT_W'(c.dummy);
      PH_WDATA: return c.wr_en ? CNT_W'((int'(c.wr_nm1) + 1) * BYTE_BITS) : '0;
      PH_RDATA: return c.rd_en ? CNT_W'((int'(c.rd_nm1) + 1) * BYTE_BITS) : '0;
      default:  return '0;
    endcase
  endfunction

  function automatic phase_e next_phase(phase_e cur, cmd_t c);
    phase_e r = PH_IDLE;
    for (int p = int'(PH_RDATA); p > int'(cur); p--) begin
      if (phase_bits(phase_e'(p), c) != '0) r = phase_e'(p);
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_t             cfg,
  output phase_e           phase,
  output logic [CNT_W-1:0] bitcnt,
  output logic             last_bit,
  output logic             busy
);
  phase_e phase_nxt;

  assign busy      = (phase != PH_IDLE);
  assign last_bit  = busy && (bitcnt == phase_bits(phase, cfg) - CNT_W'(1));
  assign phase_nxt = next_phase(phase, cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        phase  <= PH_OPC;
        bitcnt <= '0;
      end
    end else if (last_bit) begin
      phase  <= phase_nxt;
      bitcnt <= '0;
    end else begin
      bitcnt <= bitcnt + CNT_W'(1);
    end
  end

  p_start_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (phase == PH_OPC && bitcnt == '0));
  p_forward_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (phase == PH_IDLE || phase >= $past(phase)));
  p_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_bit) |=> busy);
  p_cnt_in_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitcnt < phase_bits(phase, cfg)));
endmodule

// File: rtl/fcs_tx.sv
module fcs_tx
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [7:0]       op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] bitcnt,
  input  logic [CNT_W-1:0] addr_bits,
  output logic             mosi
);
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  aidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (capture) begin
      op_q   <= op_in;
      addr_q <= addr_in;
      wd_q   <= wdata_in;
    end
  end

  // Byte k, bit 7-j: MSB first within byte, byte 0 first.
  assign idx  = {IDX_W'(bitcnt) >> 3, ~bitcnt[2:0]} ;
  assign aidx = addr_bits - CNT_W'(1) - bitcnt;

  always_comb begin
    case (phase)
      PH_OPC:   mosi = op_q[~bitcnt[2:0]];
      PH_ADDR:  mosi = addr_q[aidx[4:0]];
      PH_WDATA: mosi = wd_q[idx];
      default:  mosi = 1'b0;
    endcase
  end

  p_dummy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY) |-> !mosi);
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(wd_q));
endmodule

// File: rtl/fcs_rx.sv
module fcs_rx
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] bitcnt,
  input  logic             miso,
  output logic [DATA_W-1:0] rdata
);
  logic [IDX_W-1:0] widx;

  assign widx = {IDX_W'(bitcnt) >> 3, ~bitcnt[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clear) begin
      rdata <= '0;
    end else if (phase == PH_RDATA) begin
      rdata[widx] <= miso;
    end
  end

  p_rx_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RDATA) |=> (rdata[$past(widx)] == $past(miso)));
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RDATA && !clear) |=> $stable(rdata));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic [31:0] addr_in,
  input  logic [31:0] wdata_lo,
  input  logic [31:0] wdata_hi,
  output logic [31:0] rdata_lo,
  output logic [31:0] rdata_hi,
  output logic        spi_sclk_en,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  cmd_t             cmd_q;
  cmd_t             cmd_in;
  phase_e           phase;
  logic [CNT_W-1:0] bitcnt;
  logic             last_bit;
  logic             busy;
  logic             wr_accept;
  logic             start_evt;
  logic             rx_clear;
  logic [DATA_W-1:0] rx_word;

  assign cmd_in    = cmd_t'(cmd_wdata);
  assign wr_accept = cmd_wr && !busy;
  assign start_evt = wr_accept && cmd_in.go;
  assign rx_clear  = start_evt && cmd_in.rd_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         cmd_q <= '0;
    else if (wr_accept) cmd_q <= cmd_in;
  end

  fcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .cfg(cmd_q),
    .phase(phase), .bitcnt(bitcnt), .last_bit(last_bit), .busy(busy)
  );

  fcs_tx u_tx (
    .clk(clk), .rst_n(rst_n), .capture(start_evt), .op_in(cmd_in.opcode),
    .addr_in(addr_in), .wdata_in({wdata_hi, wdata_lo}),
    .phase(phase), .bitcnt(bitcnt), .addr_bits(phase_bits(PH_ADDR, cmd_q)),
    .mosi(spi_mosi)
  );

  fcs_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .phase(phase),
    .bitcnt(bitcnt), .miso(spi_miso), .rdata(rx_word)
  );

  assign rdata_lo    = rx_word[31:0];
  assign rdata_hi    = rx_word[63:32];
  assign cmd_rdata   = {cmd_q[31:2], busy, 1'b0};
  assign spi_cs_n    = !busy;
  assign spi_sclk_en = busy;

  p_ignore_busy_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));
  p_no_go_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_wr && cmd_wdata[0])) |=> !busy);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && next_phase(phase, cmd_q) == PH_IDLE) |=> spi_cs_n);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [31:0] addr_in = '0;
  logic [31:0] wdata_lo = '0;
  logic [31:0] wdata_hi = '0;
  logic [31:0] rdata_lo, rdata_hi;
  logic        spi_sclk_en, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .addr_in(addr_in), .wdata_lo(wdata_lo),
    .wdata_hi(wdata_hi), .rdata_lo(rdata_lo), .rdata_hi(rdata_hi),
    .spi_sclk_en(spi_sclk_en), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  typedef struct packed {
    logic [31:0] cmd;
    logic [31:0] adr;
    logic [31:0] wlo;
    logic [31:0] whi;
    logic [63:0] rx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h05800001, 32'h0, 32'h0, 32'h0, 64'h00000000_000000A5},
    '{32'h06000001, 32'hFFFFFFFF, 32'h0, 32'h0, 64'h0},
    '{32'hD80A0001, 32'hAB123456, 32'h0, 32'h0, 64'h0},
    '{32'h9FFB0401, 32'h89ABCDEF, 32'h0, 32'h0, 64'h1122334455667788},
    '{32'h0100C001, 32'h0, 32'h44332211, 32'h99887755, 64'h0},
    '{32'h3CA0F181, 32'h0, 32'h0F1E2D3C, 32'h4B5A6978, 64'hDEADBEEF_CAFE5A69}
  };

  logic exp_bits [256];
  logic got_bits [256];
  int   exp_len, rd_start;
  logic [63:0] exp_rx = '0;

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Builds the expected serial stream from the requirement text.
  task automatic build_expected(input vec_t v);
    int n = 0;
    int ab, wb, rb;
    logic [63:0] wall;
    wall = {v.whi, v.wlo};
    for (int i = 0; i < 8; i++) begin exp_bits[n] = v.cmd[31-i]; n++; end
    if (v.cmd[19]) begin
      ab = (int'(v.cmd[17:16]) + 1) * 8;
      for (int i = 0; i < ab; i++) begin exp_bits[n] = v.adr[ab-1-i]; n++; end
    end
    for (int i = 0; i < int'(v.cmd[11:7]); i++) begin exp_bits[n] = 1'b0; n++; end
    if (v.cmd[15]) begin
      wb = int'(v.cmd[14:12]) + 1;
      for (int k = 0; k < wb; k++)
        for (int b = 7; b >= 0; b--) begin exp_bits[n] = wall[k*8+b]; n++; end
    end
    rd_start = n;
    rb = v.cmd[23] ? int'(v.cmd[22:20]) + 1 : 0;
    for (int i = 0; i < rb*8; i++) begin exp_bits[n] = 1'b0; n++; end
    exp_len = n;
    if (v.cmd[23]) begin
      exp_rx = '0;
      for (int k = 0; k < rb; k++) exp_rx[k*8 +: 8] = v.rx[k*8 +: 8];
    end
  endtask

  task automatic run_cmd(input vec_t v, input int intrude_at, input string name);
    int n = 0;
    logic framing_ok = 1'b1;
    logic stream_ok;
    build_expected(v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = v.cmd; addr_in = v.adr;
    wdata_lo = v.wlo; wdata_hi = v.whi;
    forever begin
      @(negedge clk);
      cmd_wr = 1'b0;
      addr_in = ~v.adr; wdata_lo = ~v.wlo; wdata_hi = ~v.whi;
      if (!cmd_rdata[1] || n >= 255) break;
      if (spi_cs_n || !spi_sclk_en) framing_ok = 1'b0;
      got_bits[n] = spi_mosi;
      if (n >= rd_start && n < exp_len) begin
        int r = n - rd_start;
        spi_miso = v.rx[(r/8)*8 + 7 - (r%8)];
      end else begin
        spi_miso = 1'b0;
      end
      if (n == intrude_at) begin cmd_wr = 1'b1; cmd_wdata = 32'h06000001; end
      n++;
    end
    stream_ok = (n == exp_len);
    for (int i = 0; i < n && i < exp_len; i++)
      if (got_bits[i] !== exp_bits[i]) stream_ok = 1'b0;
    check(n == exp_len, {"R2 busy length ", name}, 64'(n), 64'(exp_len));
    check(stream_ok, {"R3 R4 R5 R6 R8 mosi stream ", name}, 64'(n), 64'(exp_len));
    check(framing_ok, {"R9 framing while busy ", name}, 64'(framing_ok), 64'd1);
    check(spi_cs_n && !spi_sclk_en, {"R9 release ", name},
          64'({spi_cs_n, spi_sclk_en}), 64'b10);
    check({rdata_hi, rdata_lo} == exp_rx, {"R7 R12 receive words ", name},
          {rdata_hi, rdata_lo}, exp_rx);
    check(cmd_rdata[31:2] == v.cmd[31:2], {"R10 command readback ", name},
          64'(cmd_rdata), 64'({v.cmd[31:2], 2'b00}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n && !spi_sclk_en && !cmd_rdata[1], "R1 idle pins",
          64'({spi_cs_n, spi_sclk_en, cmd_rdata[1]}), 64'b100);
    check({rdata_hi, rdata_lo} == 64'h0, "R1 receive words", {rdata_hi, rdata_lo}, 64'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) run_cmd(VECS[i], -1, $sformatf("vec%0d", i));

    // R11: go bit clear starts nothing, word is stored
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = 32'h05800000;
    @(negedge clk);
    cmd_wr = 1'b0;
    begin
      logic quiet = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (cmd_rdata[1] || !spi_cs_n || spi_sclk_en) quiet = 1'b0;
        @(negedge clk);
      end
      check(quiet, "R11 no start without go", 64'(quiet), 64'd1);
      check(cmd_rdata == 32'h05800000, "R11 word stored", 64'(cmd_rdata), 64'h05800000);
      check({rdata_hi, rdata_lo} == exp_rx, "R12 receive words unchanged",
            {rdata_hi, rdata_lo}, exp_rx);
    end

    // R10: write during a long command is ignored
    run_cmd(VECS[3], 5, "busy write at cycle 5");
    run_cmd(VECS[5], 40, "busy write late");

    // R12: command without read leaves receive words
    run_cmd(VECS[2], -1, "no-read after read");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule